// File: doc/BRIEF.md
# Nonlinear-Ratio External Clock Divider

This block derives a slower clock for an external audio or peripheral device from a fixed 96 MHz source clock. Software programs a 6-bit ratio code held inside a 16-bit control register. The code does not give the divide count directly. Small codes map onto every divisor from 2 to 8. Larger codes step the divisor in twos up to 96, so no odd divisor above 8 can be selected. Bit 0 of the register selects the clock source, and the divider runs only while that bit is zero.

A helper turns a requested output frequency in Hz into a legal ratio code. It picks the smallest legal divisor whose output does not exceed the request. When no divisor meets that condition, it picks 96. Software can apply the result with a dedicated rate write. That write replaces only the ratio field and clears the source-select bit. A new divisor always waits for the end of the current output period, so the output never has a truncated or stretched cycle.

Top module: `nlr_clkdiv`

## Requirements
- R1: Ratio code c in register bits 7:2 selects divisor d. If c <= 6 then d = c + 2. If c > 6 then d = 8 + 2*(c - 6). Codes above 50 are held at d = 96. Each output period lasts d source cycles.
- R2: For even d the output is high for d/2 cycles and low for d/2 cycles. For odd d it is high for (d-1)/2 cycles and low for (d+1)/2 cycles.
- R3: A divisor change written mid-period takes effect only after the current output period completes in full.
- R4: While register bit 0 is 1, clk_out is held low. Once the bit returns to 0, the output restarts with a full period.
- R5: fit_code encodes the smallest divisor d, taken from 2..8 and the even values 10..94, for which rate_hz >= floor(96000000/d). If no such divisor exists, d is 96. The encoding is d-2 for d <= 8 and (d-8)/2+6 above 8.
- R6: A rate write (rate_we) places fit_code in bits 7:2 and clears bit 0. It leaves bit 1 and bits 15:8 unchanged.
- R7: A full write (reg_we) stores all 16 bits, and reg_rdata reads them back. When reg_we and rate_we are both high in the same cycle, the full write takes precedence.
- R8: After reset the register reads 0 and clk_out is low. The divide-by-2 output starts on the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 96 MHz source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Full control register write strobe |
| reg_wdata | input | 16 | Full write data |
| rate_we | input | 1 | Rate write strobe; applies the fitted code |
| rate_hz | input | 27 | Requested output frequency in Hz |
| reg_rdata | output | 16 | Control register contents |
| fit_code | output | 6 | Ratio code fitted to rate_hz |
| clk_out | output | 1 | Divided clock |

## Verification
The bench measures high and low run lengths around the code 6/7 boundary, where the divisor jumps from 8 to 10. A decoder that stayed linear would produce 9 there. The bench also drives code 63, where a design without the clamp would overrun to 122. The odd divisors 3 and 7 show whether the duty cycle favours the low phase. A design that loaded a new divisor straight away would cut short the 16-cycle period that the bench interrupts. Fit requests just below the divide-by-8 output, and requests near zero, reveal a search that fails to skip odd divisors or fails to fall back to 96.

// File: rtl/nlr_clkdiv_pkg.sv
// Shared helpers: mapping between ratio code and divide count.
// Assumes dense_max is even and at least 2.
package nlr_clkdiv_pkg;

    // Ratio code to divisor, clamped at max_div.
    function automatic int unsigned code2div(input int unsigned code,
                                             input int unsigned dense_max,
                                             input int unsigned max_div);
        int unsigned d;
        if (code <= dense_max - 2) d = code + 2;
        else                       d = dense_max + 2 * (code - (dense_max - 2));
        if (d > max_div) d = max_div;
        return d;
    endfunction

    // Legal divisor to ratio code.
    function automatic int unsigned div2code(input int unsigned d,
                                             input int unsigned dense_max);
        if (d <= dense_max) return d - 2;
        return (d - dense_max) / 2 + (dense_max - 2);
    endfunction

endpackage

// File: rtl/nlr_ctrl_reg.sv
// Control register. A full write replaces every bit. A code write replaces
// only the ratio field and clears the source-select bit (bit 0).
// Assumes CODE_LSB >= 1 so that bit 0 lies outside the field.
module nlr_ctrl_reg #(
    parameter int REG_W    = 16,
    parameter int CODE_W   = 6,
    parameter int CODE_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              code_we,
    input  logic [CODE_W-1:0] code_wdata,
    output logic [REG_W-1:0]  reg_q
);
    // Register update; the full write has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (reg_we) begin
            reg_q <= reg_wdata;
        end else if (code_we) begin
            reg_q[CODE_LSB +: CODE_W] <= code_wdata;
            reg_q[0]                  <= 1'b0;
        end
    end
endmodule

// File: rtl/nlr_rate_fit.sv
// Rate fitter: picks the smallest legal divisor whose output frequency does
// not exceed the request, falling back to MAX_DIV. Odd divisors above
// DENSE_MAX are not legal. Purely combinational.
module nlr_rate_fit
    import nlr_clkdiv_pkg::*;
#(
    parameter int SRC_HZ    = 96_000_000,
    parameter int RATE_W    = 27,
    parameter int CODE_W    = 6,
    parameter int DENSE_MAX = 8,
    parameter int MAX_DIV   = 96
) (
    input  logic [RATE_W-1:0] rate_hz,
    output logic [CODE_W-1:0] fit_code
);
    logic [MAX_DIV-1:2] hit;

    // One comparator per candidate divisor against a constant quotient.
    for (genvar d = 2; d < MAX_DIV; d++) begin : g_cand
        if (d > DENSE_MAX && (d % 2) == 1) begin : g_skip
            assign hit[d] = 1'b0;
        end else begin : g_cmp
            localparam logic [RATE_W-1:0] QUOT = RATE_W'(SRC_HZ / d);
            assign hit[d] = (rate_hz >= QUOT);
        end
    end

    // Priority pick of the smallest hitting divisor.
    always_comb begin
        int unsigned sel;
        sel = MAX_DIV;
        for (int d = MAX_DIV - 1; d >= 2; d--) begin
            if (hit[d]) sel = d;
        end
        fit_code = CODE_W'(div2code(sel, DENSE_MAX));
    end
endmodule

// File: rtl/nlr_div_core.sv
// Divide counter. The counter runs 0..div-1 and the output is high while the
// count is below div/2. A new target divisor is taken only at the end of a
// period. When run is low the output is held low and the counter is parked
// at the end of a period, so the next run starts a full period.
module nlr_div_core #(
    parameter int DIV_W   = 7,
    parameter int RST_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] tgt_div,
    output logic             clk_out,
    output logic [DIV_W-1:0] cur_div,
    output logic [DIV_W-1:0] cur_cnt
);
    logic [DIV_W-1:0] cnt_q, div_q, cnt_n, div_n;
    logic             out_q, out_n, wrap;

    assign wrap = (cnt_q == div_q - DIV_W'(1));

    // Next count, divisor and registered output level.
    always_comb begin
        if (!run) begin
            cnt_n = tgt_div - DIV_W'(1);
            div_n = tgt_div;
        end else if (wrap) begin
            cnt_n = '0;
            div_n = tgt_div;
        end else begin
            cnt_n = cnt_q + DIV_W'(1);
            div_n = div_q;
        end
        out_n = run && (cnt_n < (div_n >> 1));
    end

    // State registers; reset parks at the end of a divide-by-RST_DIV period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= DIV_W'(RST_DIV - 1);
            div_q <= DIV_W'(RST_DIV);
            out_q <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            div_q <= div_n;
            out_q <= out_n;
        end
    end

    assign clk_out = out_q;
    assign cur_div = div_q;
    assign cur_cnt = cnt_q;
endmodule

// File: rtl/nlr_clkdiv.sv
// Top: control register, rate fitter and divide counter. Runs on the fixed
// source clock; bit 0 of the register must be 0 for the divider to run.
module nlr_clkdiv
    import nlr_clkdiv_pkg::*;
#(
    parameter int SRC_HZ    = 96_000_000,
    parameter int REG_W     = 16,
    parameter int CODE_W    = 6,
    parameter int CODE_LSB  = 2,
    parameter int DENSE_MAX = 8,
    parameter int MAX_DIV   = 96,
    parameter int RATE_W    = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_hz,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [CODE_W-1:0] fit_code,
    output logic              clk_out
);
    localparam int DIV_W = $clog2(MAX_DIV + 1);

    logic [REG_W-1:0] reg_q;
    logic [DIV_W-1:0] tgt_div, core_div, core_cnt;
    logic             run;

    nlr_ctrl_reg #(.REG_W(REG_W), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB)) u_reg (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .code_we(rate_we), .code_wdata(fit_code), .reg_q(reg_q)
    );

    nlr_rate_fit #(.SRC_HZ(SRC_HZ), .RATE_W(RATE_W), .CODE_W(CODE_W),
                   .DENSE_MAX(DENSE_MAX), .MAX_DIV(MAX_DIV)) u_fit (
        .rate_hz(rate_hz), .fit_code(fit_code)
    );

    // Decode the stored ratio code and the run condition.
    always_comb begin
        tgt_div = DIV_W'(code2div(reg_q[CODE_LSB +: CODE_W], DENSE_MAX, MAX_DIV));
        run     = !reg_q[0];
    end

    nlr_div_core #(.DIV_W(DIV_W), .RST_DIV(2)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run), .tgt_div(tgt_div),
        .clk_out(clk_out), .cur_div(core_div), .cur_cnt(core_cnt)
    );

    assign reg_rdata = reg_q;
endmodule

// File: rtl/nlr_clkdiv_chk.sv
// Assertion checker for nlr_clkdiv, attached by bind below.
module nlr_clkdiv_chk
    import nlr_clkdiv_pkg::*;
#(
    parameter int SRC_HZ    = 96_000_000,
    parameter int REG_W     = 16,
    parameter int CODE_W    = 6,
    parameter int DENSE_MAX = 8,
    parameter int MAX_DIV   = 96,
    parameter int RATE_W    = 27,
    parameter int DIV_W     = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic              rate_we,
    input logic [REG_W-1:0]  reg_q,
    input logic [RATE_W-1:0] rate_hz,
    input logic [CODE_W-1:0] fit_code,
    input logic              clk_out,
    input logic [DIV_W-1:0]  cur_div,
    input logic [DIV_W-1:0]  cur_cnt
);
    // R1
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_div >= DIV_W'(2) && cur_div <= DIV_W'(MAX_DIV) && cur_cnt < cur_div);

    // R3
    div_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_div) |-> ($past(cur_cnt) == $past(cur_div) - DIV_W'(1)) || $past(reg_q[0]));

    // R4
    stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_q[0] |=> !clk_out);

    // R5
    fit_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_hz >= RATE_W'(SRC_HZ / code2div(fit_code, DENSE_MAX, MAX_DIV))) ||
        (code2div(fit_code, DENSE_MAX, MAX_DIV) == MAX_DIV));

    // R6
    rate_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_we && !reg_we) |=> (reg_q[REG_W-1:8] == $past(reg_q[REG_W-1:8])) &&
                                 (reg_q[1] == $past(reg_q[1])) && !reg_q[0]);
endmodule

bind nlr_clkdiv nlr_clkdiv_chk #(
    .SRC_HZ(SRC_HZ), .REG_W(REG_W), .CODE_W(CODE_W), .DENSE_MAX(DENSE_MAX),
    .MAX_DIV(MAX_DIV), .RATE_W(RATE_W), .DIV_W(DIV_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .rate_we(rate_we),
    .reg_q(reg_q), .rate_hz(rate_hz), .fit_code(fit_code),
    .clk_out(clk_out), .cur_div(core_div), .cur_cnt(core_cnt)
);

// File: tb/nlr_clkdiv_tb.sv
module nlr_clkdiv_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        rate_we = 1'b0;
    logic [26:0] rate_hz = '0;
    logic [15:0] reg_rdata;
    logic [5:0]  fit_code;
    logic        clk_out;

    int errors = 0;
    int checks = 0;

    nlr_clkdiv u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .rate_we(rate_we), .rate_hz(rate_hz), .reg_rdata(reg_rdata),
        .fit_code(fit_code), .clk_out(clk_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_div(input int code);
        int d;
        d = (code < 7) ? code + 2 : 8 + (code - 6) * 2;
        return (d > 96) ? 96 : d;
    endfunction

    function automatic int ref_fit(input int rate);
        for (int d = 2; d < 96; d++) begin
            if (d > 8 && d % 2 == 1) continue;
            if (rate >= 96000000 / d) return (d <= 8) ? d - 2 : (d - 8) / 2 + 6;
        end
        return 50;
    endfunction

    task automatic wr_full(input logic [15:0] v);
        @(negedge clk); reg_we = 1'b1; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic wr_rate(input int r);
        @(negedge clk); rate_we = 1'b1; rate_hz = 27'(r);
        @(negedge clk); rate_we = 1'b0;
    endtask

    // Measure one full high run and the following low run.
    task automatic measure(output int hi, output int lo);
        int g;
        hi = 0; lo = 0; g = 0;
        @(negedge clk);
        while (clk_out !== 1'b0 && g < 500) begin @(negedge clk); g++; end
        while (clk_out !== 1'b1 && g < 500) begin @(negedge clk); g++; end
        while (clk_out === 1'b1 && g < 500) begin hi++; @(negedge clk); g++; end
        while (clk_out === 1'b0 && g < 500) begin lo++; @(negedge clk); g++; end
    endtask

    task automatic t_reset();
        int hi, lo;
        @(negedge clk);
        chk(reg_rdata == 16'h0, "R8 reg after reset", reg_rdata, 0);
        chk(clk_out == 1'b0, "R8 out in reset", clk_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(clk_out == 1'b1, "R8 first cycle high", clk_out, 1);
        @(negedge clk);
        chk(clk_out == 1'b0, "R8 second cycle low", clk_out, 0);
        measure(hi, lo);
        chk(hi == 1 && lo == 1, "R8 div2 high", hi, 1);
    endtask

    task automatic t_duty(input int code);
        int hi, lo, d;
        d = ref_div(code);
        wr_full(16'(code << 2));
        repeat (200) @(negedge clk);
        measure(hi, lo);
        chk(hi + lo == d, $sformatf("R1 period code %0d", code), hi + lo, d);
        chk(hi == d / 2, $sformatf("R2 high code %0d", code), hi, d / 2);
        chk(lo == d - d / 2, $sformatf("R2 low code %0d", code), lo, d - d / 2);
    endtask

    task automatic t_fit(input int r);
        @(negedge clk); rate_hz = 27'(r);
        #1;
        chk(fit_code == 6'(ref_fit(r)), $sformatf("R5 fit %0d Hz", r), fit_code, ref_fit(r));
    endtask

    task automatic t_rate_write();
        int hi, lo;
        wr_full(16'hC303);
        wr_rate(11_000_000);
        #1;
        chk(reg_rdata == 16'hC31E, "R6 rate write fields", reg_rdata, 16'hC31E);
        repeat (50) @(negedge clk);
        measure(hi, lo);
        chk(hi == 5 && lo == 5, "R6 rate write divisor", hi + lo, 10);
        // simultaneous writes: full write wins
        @(negedge clk); reg_we = 1'b1; reg_wdata = 16'h5A29; rate_we = 1'b1; rate_hz = 27'd48_000_000;
        @(negedge clk); reg_we = 1'b0; rate_we = 1'b0;
        chk(reg_rdata == 16'h5A29, "R7 full write priority", reg_rdata, 16'h5A29);
        wr_full(16'h0);
        chk(reg_rdata == 16'h0, "R7 readback", reg_rdata, 0);
    endtask

    task automatic t_boundary();
        int hi, lo, g;
        wr_full(16'(10 << 2));
        repeat (60) @(negedge clk);
        hi = 0; lo = 0; g = 0;
        while (clk_out !== 1'b0 && g < 200) begin @(negedge clk); g++; end
        while (clk_out !== 1'b1 && g < 200) begin @(negedge clk); g++; end
        hi = 1;
        @(negedge clk); hi++;
        reg_we = 1'b1; reg_wdata = 16'h0;
        @(negedge clk); reg_we = 1'b0;
        while (clk_out === 1'b1 && g < 200) begin hi++; @(negedge clk); g++; end
        while (clk_out === 1'b0 && g < 200) begin lo++; @(negedge clk); g++; end
        chk(hi == 8, "R3 old high kept", hi, 8);
        chk(lo == 8, "R3 old low kept", lo, 8);
        hi = 0; lo = 0;
        while (clk_out === 1'b1 && g < 200) begin hi++; @(negedge clk); g++; end
        while (clk_out === 1'b0 && g < 200) begin lo++; @(negedge clk); g++; end
        chk(hi == 1 && lo == 1, "R3 new period", hi + lo, 2);
    endtask

    task automatic t_stop();
        int hi, lo, highs;
        wr_full(16'h0001);
        @(negedge clk);
        highs = 0;
        repeat (20) begin @(negedge clk); if (clk_out) highs++; end
        chk(highs == 0, "R4 held low", highs, 0);
        wr_full(16'h0004);
        measure(hi, lo);
        chk(hi == 1 && lo == 2, "R4 restart div3", hi * 10 + lo, 12);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_duty(0); t_duty(1); t_duty(5); t_duty(6);
        t_duty(7); t_duty(10); t_duty(50); t_duty(63);
        t_fit(48_000_000); t_fit(100_000_000); t_fit(32_000_000);
        t_fit(13_000_000); t_fit(11_000_000); t_fit(1_000_000);
        t_fit(0); t_fit(10_666_666);
        t_rate_write();
        t_boundary();
        t_stop();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule